// File: doc/BRIEF.md
# Planar Video Memory Write Mapper

This block turns a processor byte write into a write on a 32-bit video memory. The memory holds four byte planes side by side, one per byte lane. The block can map a byte in three ways. In chain-4 mapping, the low two address bits pick a single plane. In odd/even (text) mapping, a page-select bit and address bit 0 pick a single plane. In planar mapping, the 4-bit map mask picks any set of planes, and the byte is written to every chosen plane at the same word address.

Each write that takes place sets the bits of the planes it wrote in a sticky plane-updated set. The display side reads bit 2 of this set as a sign that font data may have changed, and then clears the set with a one-cycle strobe. Every memory-side output comes from a register, so a write shows at the memory one clock after the processor presents it.

Top module: `vga_plane_mapper`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mem_we` is 0 and `plane_upd` is 4'b0000.
- R2: With `chain4`=1, a write presented in cycle N appears in cycle N+1 with plane p = `cpu_addr[1:0]`, `mem_addr` = `cpu_addr` >> 2 and `mem_be` = 1 << p.
- R3: `chain4`=1 takes precedence over `odd_even`; the value of `odd_even` has no effect while chain-4 is on.
- R4: With `chain4`=0 and `odd_even`=1, the plane is p = {`page_sel`, `cpu_addr[0]`}. The byte address is ((`cpu_addr` with bit 0 cleared) << 1) | p. `mem_addr` is that byte address >> 2, which equals `cpu_addr` >> 1, and `mem_be` = 1 << p.
- R5: In chain-4 and odd/even mapping, the write is dropped (`mem_we`=0 in cycle N+1) when `map_mask[p]` is 0.
- R6: With `chain4`=0 and `odd_even`=0, `mem_addr` = `cpu_addr` and `mem_be` = `map_mask`. A mask of 0 produces no write.
- R7: `mem_wdata` carries `cpu_data` copied into all four byte lanes.
- R8: Each write that takes place ORs its `mem_be` into `plane_upd` in the same cycle that `mem_we` is high. The bits stay set until they are cleared.
- R9: `upd_clr` clears `plane_upd` on the next edge. If a write happens in the same cycle, that write's plane bits are still set.
- R10: When `wr_en`=0, `mem_we` is 0 one cycle later, and `plane_upd` only changes through `upd_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor byte write strobe |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_data | input | 8 | Processor write data |
| map_mask | input | 4 | Plane enable mask |
| chain4 | input | 1 | Chain-4 mapping select |
| odd_even | input | 1 | Odd/even mapping select |
| page_sel | input | 1 | High plane bit for odd/even mapping |
| upd_clr | input | 1 | Clear strobe for the plane-updated set |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_be | output | 4 | Per-plane byte enables |
| mem_wdata | output | 32 | Memory write data |
| plane_upd | output | 4 | Sticky set of planes written |

## Verification
A wrong plane choice shows up one cycle after the write, as a shifted `mem_be` or a wrong `mem_addr`. A mask test that is wrong shows as a write that appears or disappears. Errors in the sticky set tend to persist, so a bit lost or set wrongly stays visible on `plane_upd` through every following idle cycle until the next clear. The bench sweeps every address, mask, page bit and mapping on a 6-bit address space. After each write it runs an idle cycle, so that a stray write or a spurious change to the sticky set is caught at once.

// File: rtl/vga_plane_mapper.sv
module vga_plane_mapper #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic [3:0]        map_mask,
  input  logic              chain4,
  input  logic              odd_even,
  input  logic              page_sel,
  input  logic              upd_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        plane_upd
);

  localparam int LANES = 4;

  logic              sel_c4, sel_oe, single_q;
  logic [1:0]        plane;
  logic [LANES-1:0]  lane, be_n;
  logic [ADDR_W-1:0] addr_n;
  logic              go;

  assign sel_c4 = chain4;
  assign sel_oe = !chain4 && odd_even;
  assign plane  = sel_c4 ? cpu_addr[1:0] : {page_sel, cpu_addr[0]};
  assign lane   = 4'b0001 << plane;
  assign be_n   = (sel_c4 || sel_oe) ? (lane & map_mask) : map_mask;
  assign addr_n = sel_c4 ? {2'b00, cpu_addr[ADDR_W-1:2]} :
                  sel_oe ? {1'b0,  cpu_addr[ADDR_W-1:1]} : cpu_addr;
  assign go     = wr_en && (be_n != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      single_q  <= 1'b0;
      plane_upd <= '0;
    end else begin
      mem_we    <= go;
      mem_addr  <= addr_n;
      mem_be    <= go ? be_n : '0;
      mem_wdata <= {LANES{cpu_data}};
      single_q  <= sel_c4 || sel_oe;
      plane_upd <= (upd_clr ? '0 : plane_upd) | (go ? be_n : '0);
    end
  end

  // R6
  we_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be != 4'b0000));

  // R2
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && single_q) |-> ($countones(mem_be) == 1));

  // R5
  masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && chain4 && !map_mask[cpu_addr[1:0]]) |=> !mem_we);

  // R8
  upd_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((plane_upd & mem_be) == mem_be));

  // R9
  upd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd_clr) |-> ((plane_upd & $past(plane_upd)) == $past(plane_upd)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !mem_we);

endmodule

// File: tb/sim_vga_plane_mapper.sv
`timescale 1ns/1ps
module sim_vga_plane_mapper;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, chain4 = 1'b0, odd_even = 1'b0, page_sel = 1'b0, upd_clr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_data = '0;
  logic [3:0] map_mask = '0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be, plane_upd;
  logic [31:0] mem_wdata;

  int checks = 0, fails = 0, cycles = 0;
  logic [3:0] exp_upd = '0;

  always #2.5 clk = ~clk;

  vga_plane_mapper #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .map_mask(map_mask), .chain4(chain4),
    .odd_even(odd_even), .page_sel(page_sel), .upd_clr(upd_clr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .plane_upd(plane_upd));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic check(string tag, logic [48:0] act, logic [48:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // mode: 0 chain-4, 1 odd/even, 2 planar
  task automatic step(logic we, int mode, int a, logic [3:0] m, logic pg,
                      logic clr, logic [7:0] d, string tag);
    int plane, byte_a;
    logic e_we;
    logic [AW-1:0] e_addr;
    logic [3:0] e_be;
    @(negedge clk);
    wr_en = we; cpu_addr = AW'(a); map_mask = m; page_sel = pg;
    upd_clr = clr; cpu_data = d;
    chain4 = (mode == 0);
    odd_even = (mode == 1) || (mode == 0 && pg);
    if (mode == 0) begin
      plane = a % 4; e_addr = AW'(a / 4); e_be = m[plane] ? 4'(1 << plane) : 4'b0;
    end else if (mode == 1) begin
      plane = (pg ? 2 : 0) + (a % 2);
      byte_a = ((a - (a % 2)) * 2) + plane;
      e_addr = AW'(byte_a / 4);
      e_be = m[plane] ? 4'(1 << (byte_a % 4)) : 4'b0;
    end else begin
      e_addr = AW'(a); e_be = m;
    end
    e_we = we && (e_be != 0);
    exp_upd = (clr ? 4'b0 : exp_upd) | (e_we ? e_be : 4'b0);
    @(negedge clk);
    if (e_we)
      check(tag, {mem_we, mem_addr[5:0], mem_be, mem_wdata, plane_upd},
            {1'b1, e_addr, e_be, {4{d}}, exp_upd});
    else
      check(tag, {mem_we, 42'b0, plane_upd}, {1'b0, 42'b0, exp_upd});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", {47'b0, mem_we, |plane_upd}, 49'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {47'b0, mem_we, |plane_upd}, 49'b0);
    for (int mode = 0; mode < 3; mode++)
      for (int a = 0; a < 64; a++)
        for (int m = 0; m < 16; m++)
          for (int pg = 0; pg < 2; pg++) begin
            logic [7:0] d;
            d = 8'(a * 7 + m * 13 + pg + mode * 29);
            // R2 R3 R4 R5 R6 R7 R8 R9 (clear with write on address 5)
            step(1'b1, mode, a, 4'(m), pg[0], (a == 5 && m[0]), d,
                 mode == 0 ? "R2 R3 R5 R7 R8 R9" :
                 mode == 1 ? "R4 R5 R7 R8 R9" : "R6 R7 R8 R9");
            // R10 idle cycle, R9 clear alone on address 9
            step(1'b0, mode, a, 4'hf, pg[0], (a == 9 && m == 3), 8'hff,
                 "R10 R9 idle");
          end
    summary();
  end
endmodule